// File: doc/BRIEF.md
# Multichannel TDM Serial Receiver with Early-Frame-Sync Detection

This block receives several time-division-multiplexed serial streams. Each port has its own frame sync and two data lanes (A and B) that carry slots in parallel. A divider on the core clock makes one serial clock, and all ports share it. When a frame sync is sampled, a frame starts. The port then counts bit and slot positions. For every enabled slot it delivers the word received on each lane, together with the slot number.

A frame sync may arrive while a frame is still in progress, at any point other than the final bit of the final slot. The port treats this as a framing error. It drops the partial word, restarts on the new frame, and sets a sticky per-port bit in a shared status vector. Software clears these bits by writing one to them. An interrupt line carries the OR of the status bits that are unmasked, so software can read the status vector to see which port faulted.

Top module: `tdm_frame_monitor`

## Requirements
- R1: The serial clock `sclkOut` has a period of max(`divRatio`, 8) core cycles. It is high for the first floor(period/2) cycles of each period. Inputs are sampled at its rising edge.
- R2: A frame sync sampled high starts a frame, and slot 0 bit 0 is the next sampled bit. A word arrives MSB first. When the last bit of an enabled slot is sampled, `wordValid[p]` pulses for one core cycle, starting at that same rising edge. The word is zero-extended.
- R3: A frame holds `slotCount`+1 slots (1 to 128) of `wordLen`+1 bits (1 to 32). After the last bit of the last slot, the port idles until it samples another frame sync.
- R4: Only slot s with `slotMask[s]`=1 produces a word. `wordSlot` gives the slot number of that word.
- R5: Lane A and lane B are captured in the same slots and delivered together: `wordA` holds lane A and `wordB` holds lane B.
- R6: A frame sync sampled while the port is idle, or on the final bit of the final slot, is legal. It sets no error, and on the final bit that word is still delivered.
- R7: A frame sync sampled at any other bit of an active frame sets `errStatus[p]` of that port only, at the same edge.
- R8: After an early sync, the word in progress is not delivered, even if that bit would have completed it. Slot 0 of the new frame starts on the next bit.
- R9: Status bits are sticky. `errClr[p]`=1 clears bit p. If a set and a clear occur in the same cycle, the set wins.
- R10: `irq` is high exactly when some bit of `errStatus & errMask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| divRatio | input | DIV_W | Serial clock period in core cycles (minimum 8 enforced) |
| sclkOut | output | 1 | Generated serial clock |
| slotCount | input | 7 | Slots per frame minus one |
| wordLen | input | LEN_W | Bits per word minus one |
| slotMask | input | 128 | Per-slot enable |
| fsyncIn | input | NUM_PORTS | Frame sync per port |
| laneAIn | input | NUM_PORTS | Lane A serial data per port |
| laneBIn | input | NUM_PORTS | Lane B serial data per port |
| wordValid | output | NUM_PORTS | Word delivered strobe per port |
| wordA | output | NUM_PORTS*DATA_W | Lane A words, port p at [p*DATA_W +: DATA_W] |
| wordB | output | NUM_PORTS*DATA_W | Lane B words, same layout |
| wordSlot | output | NUM_PORTS*7 | Slot number of the delivered word |
| errClr | input | NUM_PORTS | Write-one-to-clear strobes for status |
| errMask | input | NUM_PORTS | Interrupt enable per status bit |
| errStatus | output | NUM_PORTS | Sticky framing-error flags |
| irq | output | 1 | Framing-error interrupt |

## Verification
The data word and the error flag both become visible in the core cycle that follows the serial-clock rising edge which samples the deciding bit. The monitor samples `wordValid` on falling core-clock edges, and error checks wait for that rising edge and then one falling core edge. The interrupt follows the status and mask with no register in between, so it is checked just after a falling edge. The clear test looks at the status in the cycle of the set and again in the cycle after it, because a held clear removes the bit only one cycle later.

// File: rtl/tdmfe_pkg.sv
package tdmfe_pkg;
  localparam int TDM_MAX_SLOTS = 128;
  localparam int TDM_SLOT_W    = $clog2(TDM_MAX_SLOTS);

  // Control-to-datapath strobes for one port
  typedef struct packed {
    logic                  shift;    // sample lane bits this cycle
    logic                  deliver;  // complete word in an enabled slot
    logic [TDM_SLOT_W-1:0] slot;     // slot of the word being delivered
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_fm_clkdiv.sv
module tdm_fm_clkdiv #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divRatio,
  output logic             sclk,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] period, half, cnt, cntNext;

  always_comb begin
    period  = (divRatio < MIN_V) ? MIN_V : divRatio;
    half    = period >> 1;
    tick    = (cnt >= period - 1'b1);
    cntNext = tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else begin
      cnt  <= cntNext;
      sclk <= (cntNext < half);
    end
  end
endmodule

// File: rtl/tdm_fm_ctrl.sv
module tdm_fm_ctrl
  import tdmfe_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     fsync,
  input  logic [TDM_SLOT_W-1:0]    slotLast,
  input  logic [LEN_W-1:0]         bitLast,
  input  logic [TDM_MAX_SLOTS-1:0] slotMask,
  output tdmStrobe_t               strobe,
  output logic                     errSet
);
  logic                  active;
  logic [TDM_SLOT_W-1:0] slotIdx;
  logic [LEN_W-1:0]      bitIdx;
  logic                  wordEnd, frameEnd, earlySync;

  always_comb begin
    wordEnd        = active && (bitIdx == bitLast);
    frameEnd       = wordEnd && (slotIdx == slotLast);
    earlySync      = tick && fsync && active && !frameEnd;
    strobe.shift   = tick;
    strobe.deliver = tick && wordEnd && slotMask[slotIdx] && !earlySync;
    strobe.slot    = slotIdx;
    errSet         = earlySync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      if (fsync) begin
        active  <= 1'b1;
        slotIdx <= '0;
        bitIdx  <= '0;
      end else if (active) begin
        if (wordEnd) begin
          bitIdx <= '0;
          if (frameEnd) active  <= 1'b0;
          else          slotIdx <= slotIdx + 1'b1;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_fm_dp.sv
module tdm_fm_dp
  import tdmfe_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  tdmStrobe_t                  strobe,
  input  logic [NUM_LANES-1:0]        laneIn,
  input  logic [DATA_W-1:0]           lenMask,
  output logic                        wordValid,
  output logic [NUM_LANES*DATA_W-1:0] wordOut,
  output logic [TDM_SLOT_W-1:0]       wordSlot
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DATA_W-1:0] shReg, wordR, shNext;
    assign shNext = {shReg[DATA_W-2:0], laneIn[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shReg <= '0;
        wordR <= '0;
      end else begin
        if (strobe.shift)   shReg <= shNext;
        if (strobe.deliver) wordR <= shNext & lenMask;
      end
    end
    assign wordOut[g*DATA_W +: DATA_W] = wordR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordValid <= 1'b0;
      wordSlot  <= '0;
    end else begin
      wordValid <= strobe.deliver;
      if (strobe.deliver) wordSlot <= strobe.slot;
    end
  end
endmodule

// File: rtl/tdm_fm_status.sv
module tdm_fm_status #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] errSet,
  input  logic [NUM_PORTS-1:0] errClr,
  input  logic [NUM_PORTS-1:0] errMask,
  output logic [NUM_PORTS-1:0] errStatus,
  output logic                 irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errStatus <= '0;
    else        errStatus <= (errStatus & ~errClr) | errSet;
  end

  assign irq = |(errStatus & errMask);
endmodule

// File: rtl/tdm_frame_monitor.sv
module tdm_frame_monitor
  import tdmfe_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 8,
  parameter int MIN_DIV   = 8,
  localparam int LEN_W    = $clog2(DATA_W),
  localparam int SLOT_W   = TDM_SLOT_W,
  localparam int NSLOT    = TDM_MAX_SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            divRatio,
  output logic                        sclkOut,
  input  logic [SLOT_W-1:0]           slotCount,
  input  logic [LEN_W-1:0]            wordLen,
  input  logic [NSLOT-1:0]            slotMask,
  input  logic [NUM_PORTS-1:0]        fsyncIn,
  input  logic [NUM_PORTS-1:0]        laneAIn,
  input  logic [NUM_PORTS-1:0]        laneBIn,
  output logic [NUM_PORTS-1:0]        wordValid,
  output logic [NUM_PORTS*DATA_W-1:0] wordA,
  output logic [NUM_PORTS*DATA_W-1:0] wordB,
  output logic [NUM_PORTS*SLOT_W-1:0] wordSlot,
  input  logic [NUM_PORTS-1:0]        errClr,
  input  logic [NUM_PORTS-1:0]        errMask,
  output logic [NUM_PORTS-1:0]        errStatus,
  output logic                        irq
);
  logic                 tick;
  logic [NUM_PORTS-1:0] errSet;
  logic [DATA_W-1:0]    lenMask;

  assign lenMask = {DATA_W{1'b1}} >> (LEN_W'(DATA_W - 1) - wordLen);

  tdm_fm_clkdiv #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) clkdiv_i (
    .clk(clk), .rst_n(rst_n), .divRatio(divRatio), .sclk(sclkOut), .tick(tick)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tdmStrobe_t          strobe;
    logic [2*DATA_W-1:0] laneWords;

    tdm_fm_ctrl #(.LEN_W(LEN_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fsync(fsyncIn[p]),
      .slotLast(slotCount), .bitLast(wordLen), .slotMask(slotMask),
      .strobe(strobe), .errSet(errSet[p])
    );

    tdm_fm_dp #(.DATA_W(DATA_W), .NUM_LANES(2)) dp_i (
      .clk(clk), .rst_n(rst_n), .strobe(strobe),
      .laneIn({laneBIn[p], laneAIn[p]}), .lenMask(lenMask),
      .wordValid(wordValid[p]), .wordOut(laneWords),
      .wordSlot(wordSlot[p*SLOT_W +: SLOT_W])
    );

    assign wordA[p*DATA_W +: DATA_W] = laneWords[DATA_W-1:0];
    assign wordB[p*DATA_W +: DATA_W] = laneWords[2*DATA_W-1:DATA_W];
  end

  tdm_fm_status #(.NUM_PORTS(NUM_PORTS)) status_i (
    .clk(clk), .rst_n(rst_n), .errSet(errSet), .errClr(errClr),
    .errMask(errMask), .errStatus(errStatus), .irq(irq)
  );
endmodule

// File: rtl/tdm_fm_chk.sv
module tdm_fm_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sclkOut,
  input logic [NUM_PORTS-1:0] wordValid,
  input logic [NUM_PORTS-1:0] errStatus,
  input logic [NUM_PORTS-1:0] errClr,
  input logic                 irq
);
  // R1
  sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclkOut) |=> sclkOut);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (errStatus != '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R2
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wordValid[p] |=> !wordValid[p]);

    // R2
    word_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wordValid[p] |-> $rose(sclkOut));

    // R7
    err_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(errStatus[p]) |-> $rose(sclkOut));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (errStatus[p] && !errClr[p]) |=> errStatus[p]);
  end
endmodule

bind tdm_frame_monitor tdm_fm_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclkOut(sclkOut), .wordValid(wordValid),
  .errStatus(errStatus), .errClr(errClr), .irq(irq)
);

// File: tb/tdm_frame_monitor_tb.sv
module tdm_frame_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    divRatio = 8'd8;
  logic          sclkOut;
  logic [6:0]    slotCount = '0;
  logic [4:0]    wordLen = '0;
  logic [127:0]  slotMask = '1;
  logic [NP-1:0] fsyncIn = '0, laneAIn = '0, laneBIn = '0;
  logic [NP-1:0] wordValid;
  logic [NP*DW-1:0] wordA, wordB;
  logic [NP*7-1:0]  wordSlot;
  logic [NP-1:0] errClr = '0, errMask = '1, errStatus;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  logic [72:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_frame_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .divRatio(divRatio), .sclkOut(sclkOut),
    .slotCount(slotCount), .wordLen(wordLen), .slotMask(slotMask),
    .fsyncIn(fsyncIn), .laneAIn(laneAIn), .laneBIn(laneBIn),
    .wordValid(wordValid), .wordA(wordA), .wordB(wordB), .wordSlot(wordSlot),
    .errClr(errClr), .errMask(errMask), .errStatus(errStatus), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] genWord(input int seed, input int s, input int lane);
    logic [31:0] x;
    x = 32'(seed) * 32'h9E3779B1 + 32'(s) * 32'h85EBCA6B + (lane != 0 ? 32'hC2B2AE35 : 32'h27D4EB2F);
    return x ^ (x >> 13);
  endfunction

  // bit is presented after the falling serial edge, sampled at the next rising edge
  task automatic driveBit(input int p, input bit fs, input bit a, input bit b);
    @(negedge sclkOut);
    #1;
    fsyncIn    = '0;
    fsyncIn[p] = fs;
    laneAIn[p] = a;
    laneBIn[p] = b;
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) driveBit(0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic waitTick();
    @(posedge sclkOut);
    @(negedge clk);
  endtask

  // driver: pushes expected words for enabled, completed slots
  task automatic sendFrame(input int p, input int seed, input bit leadSync,
                           input int abortAt, input bit syncOnLast);
    int nS, wl, total;
    logic [31:0] lmask, va, vb;
    bit fs;
    nS = int'(slotCount) + 1;
    wl = int'(wordLen) + 1;
    total = nS * wl;
    lmask = (wl == 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 1);
    if (leadSync) driveBit(p, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < total; k++) begin
      int s, b;
      s = k / wl;
      b = k % wl;
      va = genWord(seed, s, 0) & lmask;
      vb = genWord(seed, s, 1) & lmask;
      fs = (k == abortAt) || (syncOnLast && k == total - 1);
      if (b == wl - 1 && slotMask[s] && k != abortAt)
        expQ.push_back({2'(p), 7'(s), va, vb});
      driveBit(p, fs, va[wl-1-b], vb[wl-1-b]);
      if (k == abortAt) break;
    end
  endtask

  // monitor: R2 R4 R5 word content, slot and lane placement
  always @(negedge clk) begin
    if (running) begin
      for (int p = 0; p < NP; p++) begin
        if (wordValid[p]) begin
          logic [72:0] got, exp;
          got = {2'(p), wordSlot[p*7 +: 7], wordA[p*DW +: DW], wordB[p*DW +: DW]};
          checks++;
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected word actual=%0h expected=none", got);
          end else begin
            exp = expQ.pop_front();
            if (got !== exp) begin
              errors++;
              $display("FAIL R2/R4/R5 word actual=%0h expected=%0h", got, exp);
            end
          end
        end
      end
    end
  end

  task automatic measure(output int per, output int hi);
    time t0, t1, t2;
    @(posedge sclkOut); t0 = $time;
    @(negedge sclkOut); t1 = $time;
    @(posedge sclkOut); t2 = $time;
    per = int'((t2 - t0) / CLK_PERIOD);
    hi  = int'((t1 - t0) / CLK_PERIOD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int per, hi;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    chk(errStatus == 0, "R9 reset status", 64'(errStatus), 0);
    chk(irq == 0, "R10 reset irq", 64'(irq), 0);
    chk(wordValid == 0, "R2 reset valid", 64'(wordValid), 0);

    // R1 clock divider with clamp and with a larger ratio
    divRatio = 8'd3;
    repeat (2) @(posedge sclkOut);
    measure(per, hi);
    chk(per == 8, "R1 clamped period", 64'(per), 8);
    chk(hi == 4, "R1 clamped high time", 64'(hi), 4);
    divRatio = 8'd12;
    repeat (2) @(posedge sclkOut);
    measure(per, hi);
    chk(per == 12, "R1 period", 64'(per), 12);
    chk(hi == 6, "R1 high time", 64'(hi), 6);
    divRatio = 8'd8;
    repeat (2) @(posedge sclkOut);

    // R3 R5 R6: 4 slots x 32 bits, back-to-back frames with sync on the last bit
    slotCount = 7'd3; wordLen = 5'd31; slotMask = '1;
    sendFrame(0, 11, 1'b1, -1, 1'b1);
    sendFrame(0, 12, 1'b0, -1, 1'b0);
    idleBits(3);
    chk(errStatus == 0, "R6 sync on last bit legal", 64'(errStatus), 0);
    chk(expQ.size() == 0, "R3 all words delivered", 64'(expQ.size()), 0);
    sendFrame(0, 13, 1'b1, -1, 1'b0);
    idleBits(2);
    chk(errStatus == 0, "R6 sync while idle legal", 64'(errStatus), 0);

    // R4 slot mask: 8 slots x 8 bits, only slots 0,2,5,7
    slotCount = 7'd7; wordLen = 5'd7; slotMask = 128'hA5;
    sendFrame(0, 21, 1'b1, -1, 1'b0);
    idleBits(2);
    chk(expQ.size() == 0, "R4 masked frame complete", 64'(expQ.size()), 0);

    // R7 R8: early sync mid-word on port 1
    slotCount = 7'd3; slotMask = '1;
    sendFrame(1, 31, 1'b1, 13, 1'b0);
    waitTick();
    chk(errStatus == 4'b0010, "R7 port 1 flagged", 64'(errStatus), 4'b0010);
    chk(irq == 1'b1, "R10 irq on error", 64'(irq), 1);
    sendFrame(1, 32, 1'b0, -1, 1'b0);
    idleBits(2);
    chk(expQ.size() == 0, "R8 resync frame delivered", 64'(expQ.size()), 0);

    // R8: early sync on the bit that ends slot 0 on port 2, then at slot 0 bit 0
    sendFrame(2, 41, 1'b1, 7, 1'b0);
    waitTick();
    chk(errStatus == 4'b0110, "R7 port 2 flagged", 64'(errStatus), 4'b0110);
    sendFrame(2, 42, 1'b0, 0, 1'b0);
    sendFrame(2, 43, 1'b0, -1, 1'b0);
    idleBits(2);
    chk(expQ.size() == 0, "R8 truncated words dropped", 64'(expQ.size()), 0);

    // R10 masking
    @(negedge clk); errMask = 4'b0001; #1;
    chk(irq == 1'b0, "R10 masked irq", 64'(irq), 0);
    errMask = 4'b0100; #1;
    chk(irq == 1'b1, "R10 unmasked irq", 64'(irq), 1);
    errMask = '1;

    // R9 write-one-to-clear of one bit
    @(negedge clk); errClr = 4'b0010;
    @(negedge clk); errClr = '0;
    chk(errStatus == 4'b0100, "R9 clear one bit", 64'(errStatus), 4'b0100);
    @(negedge clk);
    chk(errStatus == 4'b0100, "R9 sticky", 64'(errStatus), 4'b0100);

    // R9 set wins over a held clear on port 3
    errClr = 4'b1000;
    sendFrame(3, 51, 1'b1, 5, 1'b0);
    waitTick();
    chk(errStatus[3] == 1'b1, "R9 set wins", 64'(errStatus[3]), 1);
    @(negedge clk);
    chk(errStatus[3] == 1'b0, "R9 held clear", 64'(errStatus[3]), 0);
    errClr = '1;
    sendFrame(3, 52, 1'b0, -1, 1'b0);
    errClr = '0;
    idleBits(2);
    chk(errStatus == 0, "R9 all cleared", 64'(errStatus), 0);
    chk(irq == 0, "R10 irq low", 64'(irq), 0);

    // R3 boundaries: 128 slots x 4 bits, even slots enabled
    slotCount = 7'd127; wordLen = 5'd3; slotMask = {64{2'b01}};
    sendFrame(0, 61, 1'b1, -1, 1'b0);
    idleBits(2);
    chk(expQ.size() == 0, "R3 128-slot frame", 64'(expQ.size()), 0);

    // R3 R6: one slot of one bit, sync on every bit is legal
    slotCount = 7'd0; wordLen = 5'd0; slotMask = '1;
    sendFrame(3, 71, 1'b1, -1, 1'b1);
    sendFrame(3, 72, 1'b0, -1, 1'b1);
    sendFrame(3, 73, 1'b0, -1, 1'b0);
    idleBits(2);
    chk(expQ.size() == 0, "R3 single-bit frames", 64'(expQ.size()), 0);
    chk(errStatus == 0, "R6 single-bit no error", 64'(errStatus), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule